// File: doc/BRIEF.md
# Endpoint Control Register Bank

This block holds one 16-bit control and status word for each endpoint of a USB device core (eight endpoints by default). Software reaches the words over a simple register port. The transaction engine reports each completed OUT, SETUP or IN transaction on a strobe interface. The block then raises the matching completion flag, flips the data toggle and moves the handshake state from valid to NAK. Until software hands the buffer back, the endpoint answers NAK.

Writes from software use invert-on-one semantics for the handshake-state and data-toggle fields. They use clear-only semantics for the two completion flags. Software can change one field without first reading the word, and it cannot undo a hardware update that it has not yet seen. A lookup port gives the engine the handshake state, toggles, type and kind of any endpoint, so the engine can pick ACK, NAK or STALL. The block also raises a request for the lowest-numbered endpoint that has a completion flag set.

Top module: `ep_ctrl_bank`

## Requirements
- R1: After reset every endpoint word reads 0x0000 and `ctr_req` is low.
- R2: The transfer type (bits 10:9, where 00 is bulk, 01 control, 10 isochronous and 11 interrupt), the kind bit (bit 8) and the endpoint address (bits 3:0) take the written value on every write to the word.
- R3: For the handshake fields (receive in bits 13:12, transmit in bits 5:4, where 00 is disabled, 01 stall, 10 NAK and 11 valid), a written 1 inverts the bit and a written 0 leaves it unchanged.
- R4: For the data toggles (receive in bit 14, transmit in bit 6), a written 1 inverts the bit and a written 0 leaves it unchanged.
- R5: For the completion flags (receive in bit 15, transmit in bit 7), a written 0 clears the flag and a written 1 leaves it unchanged.
- R6: An OUT transaction (`xfer_kind` 00) on an endpoint whose receive state is valid sets bit 15, inverts bit 14, sets the receive state to NAK and clears bit 11.
- R7: A SETUP transaction (`xfer_kind` 10) on a valid receive endpoint does what R6 describes and also sets bit 11. Software writes never change bit 11.
- R8: An IN transaction (`xfer_kind` 01) on an endpoint whose transmit state is valid sets bit 7, inverts bit 6 and sets the transmit state to NAK.
- R9: A transaction aimed at a direction that is not valid has no effect on the word. The reserved `xfer_kind` 11 also has no effect.
- R10: When a software write and a transaction hit the same word in one cycle, the transaction decides the completion flag, toggle and handshake state of its own direction. The plain fields and the other direction follow the write.
- R11: `ctr_req` is high while any endpoint has bit 15 or bit 7 set, and `ctr_ep` then gives the lowest such endpoint.
- R12: The engine lookup port shows, without a clock delay, the handshake states, toggles, type and kind of the endpoint named by `eng_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_ep | input | IDX_W | Endpoint written |
| wr_data | input | 16 | Write data |
| rd_ep | input | IDX_W | Endpoint read |
| rd_data | output | 16 | Current word of `rd_ep` |
| xfer_valid | input | 1 | Completed-transaction strobe |
| xfer_ep | input | IDX_W | Endpoint of the transaction |
| xfer_kind | input | 2 | 00 OUT, 01 IN, 10 SETUP, 11 reserved |
| eng_sel | input | IDX_W | Endpoint looked up by the engine |
| eng_rx_stat | output | 2 | Receive handshake state |
| eng_tx_stat | output | 2 | Transmit handshake state |
| eng_rx_tog | output | 1 | Receive data toggle |
| eng_tx_tog | output | 1 | Transmit data toggle |
| eng_type | output | 2 | Transfer type |
| eng_kind | output | 1 | Kind bit |
| ctr_req | output | 1 | Some completion flag is set |
| ctr_ep | output | IDX_W | Lowest endpoint with a flag set |

## Verification
The assertions assume that `xfer_valid` comes as a one-cycle strobe with a settled endpoint number and kind. They also assume that the internal reset has been released. Under those conditions, every change in the words comes from either a write or a qualified transaction. The stimulus drives all inputs on the falling edge and holds each strobe for exactly one cycle. It does not send a transaction while reset is still in its synchronizer. Collisions are produced on purpose, and only by driving both strobes in the same cycle.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    HS_OFF   = 2'b00,
    HS_STALL = 2'b01,
    HS_NAK   = 2'b10,
    HS_READY = 2'b11
  } hs_t;

  typedef enum logic [1:0] {
    XK_OUT   = 2'b00,
    XK_IN    = 2'b01,
    XK_SETUP = 2'b10,
    XK_RSVD  = 2'b11
  } xk_t;

  // Field order is the bit layout, most significant first.
  typedef struct packed {
    logic       rx_done;
    logic       rx_tog;
    hs_t        rx_hs;
    logic       setup;
    logic [1:0] ttype;
    logic       kind;
    logic       tx_done;
    logic       tx_tog;
    hs_t        tx_hs;
    logic [3:0] addr;
  } ep_word_t;

endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ep_word_reg.sv
module ep_word_reg
  import ep_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sw_wr,
  input  ep_word_t sw_data,
  input  logic     hw_out,
  input  logic     hw_setup,
  input  logic     hw_in,
  output ep_word_t cur_o
);
  ep_word_t cur_q, nxt;
  logic     rx_ok, tx_ok, upd_en;

  assign rx_ok  = (hw_out || hw_setup) && (cur_q.rx_hs == HS_READY);
  assign tx_ok  = hw_in && (cur_q.tx_hs == HS_READY);
  assign upd_en = sw_wr || rx_ok || tx_ok;

  always_comb begin
    nxt = cur_q;
    if (sw_wr) begin
      nxt.rx_done = cur_q.rx_done & sw_data.rx_done;
      nxt.tx_done = cur_q.tx_done & sw_data.tx_done;
      nxt.rx_tog  = cur_q.rx_tog ^ sw_data.rx_tog;
      nxt.tx_tog  = cur_q.tx_tog ^ sw_data.tx_tog;
      nxt.rx_hs   = hs_t'(cur_q.rx_hs ^ sw_data.rx_hs);
      nxt.tx_hs   = hs_t'(cur_q.tx_hs ^ sw_data.tx_hs);
      nxt.ttype   = sw_data.ttype;
      nxt.kind    = sw_data.kind;
      nxt.addr    = sw_data.addr;
    end
    if (rx_ok) begin
      nxt.rx_done = 1'b1;
      nxt.rx_tog  = ~cur_q.rx_tog;
      nxt.rx_hs   = HS_NAK;
      nxt.setup   = hw_setup;
    end
    if (tx_ok) begin
      nxt.tx_done = 1'b1;
      nxt.tx_tog  = ~cur_q.tx_tog;
      nxt.tx_hs   = HS_NAK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (upd_en) cur_q <= nxt;
  end

  assign cur_o = cur_q;

  // R6
  rx_done_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |=> (cur_q.rx_done && cur_q.rx_hs == HS_NAK));

  // R8
  tx_done_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> (cur_q.tx_done && cur_q.tx_hs == HS_NAK));

  // R5
  rx_done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.rx_done && !(sw_wr && !sw_data.rx_done)) |=> cur_q.rx_done);

  // R7
  setup_sw_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ok |=> $stable(cur_q.setup));

  // R3
  rx_hs_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !rx_ok) |=> (cur_q.rx_hs == hs_t'($past(cur_q.rx_hs) ^ $past(sw_data.rx_hs))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !rx_ok && !tx_ok) |=> $stable(cur_q));
endmodule

// File: rtl/ep_ctr_pick.sv
module ep_ctr_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pending,
  output logic             req,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] below_mask;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) idx = i[IDX_W-1:0];
    end
  end

  assign req        = |pending;
  assign below_mask = (N'(1) << idx) - N'(1);

  // R11
  ctr_pick_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> pending[idx]);

  // R11
  ctr_pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((pending & below_mask) == '0));
endmodule

// File: rtl/ep_ctrl_bank.sv
module ep_ctrl_bank
  import ep_bank_pkg::*;
#(
  parameter  int NUM_EP = 8,
  localparam int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_ep,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_ep,
  output logic [WORD_W-1:0] rd_data,
  input  logic              xfer_valid,
  input  logic [IDX_W-1:0]  xfer_ep,
  input  logic [1:0]        xfer_kind,
  input  logic [IDX_W-1:0]  eng_sel,
  output logic [1:0]        eng_rx_stat,
  output logic [1:0]        eng_tx_stat,
  output logic              eng_rx_tog,
  output logic              eng_tx_tog,
  output logic [1:0]        eng_type,
  output logic              eng_kind,
  output logic              ctr_req,
  output logic [IDX_W-1:0]  ctr_ep
);
  localparam logic [IDX_W:0] EP_LIM = NUM_EP[IDX_W:0];

  logic        rst_n_int;
  ep_word_t    words [NUM_EP];
  logic [NUM_EP-1:0] pending;
  ep_word_t    sw_word, eng_word;
  xk_t         kind_in;

  assign sw_word = ep_word_t'(wr_data);
  assign kind_in = xk_t'(xfer_kind);

  ep_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit_wr, hit_xf;
    assign hit_wr = wr_en && (wr_ep == IDX_W'(i));
    assign hit_xf = xfer_valid && (xfer_ep == IDX_W'(i));

    ep_word_reg u_word (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .sw_wr    (hit_wr),
      .sw_data  (sw_word),
      .hw_out   (hit_xf && kind_in == XK_OUT),
      .hw_setup (hit_xf && kind_in == XK_SETUP),
      .hw_in    (hit_xf && kind_in == XK_IN),
      .cur_o    (words[i])
    );

    assign pending[i] = words[i].rx_done || words[i].tx_done;
  end

  ep_ctr_pick #(.N(NUM_EP), .IDX_W(IDX_W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .pending (pending),
    .req     (ctr_req),
    .idx     (ctr_ep)
  );

  assign rd_data  = ({1'b0, rd_ep} < EP_LIM) ? WORD_W'(words[rd_ep]) : '0;
  assign eng_word = ({1'b0, eng_sel} < EP_LIM) ? words[eng_sel] : '0;

  assign eng_rx_stat = eng_word.rx_hs;
  assign eng_tx_stat = eng_word.tx_hs;
  assign eng_rx_tog  = eng_word.rx_tog;
  assign eng_tx_tog  = eng_word.tx_tog;
  assign eng_type    = eng_word.ttype;
  assign eng_kind    = eng_word.kind;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |=> !ctr_req);
endmodule

// File: tb/ep_ctrl_bank_test.sv
`timescale 1ns/1ps
module ep_ctrl_bank_test;
  localparam int NEP = 8;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_ep = '0;
  logic [15:0] wr_data = '0;
  logic [IW-1:0] rd_ep = '0;
  logic [15:0] rd_data;
  logic xfer_valid = 1'b0;
  logic [IW-1:0] xfer_ep = '0;
  logic [1:0] xfer_kind = '0;
  logic [IW-1:0] eng_sel = '0;
  logic [1:0] eng_rx_stat, eng_tx_stat, eng_type;
  logic eng_rx_tog, eng_tx_tog, eng_kind, ctr_req;
  logic [IW-1:0] ctr_ep;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ep_ctrl_bank #(.NUM_EP(NEP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ep(wr_ep), .wr_data(wr_data),
    .rd_ep(rd_ep), .rd_data(rd_data), .xfer_valid(xfer_valid), .xfer_ep(xfer_ep),
    .xfer_kind(xfer_kind), .eng_sel(eng_sel), .eng_rx_stat(eng_rx_stat),
    .eng_tx_stat(eng_tx_stat), .eng_rx_tog(eng_rx_tog), .eng_tx_tog(eng_tx_tog),
    .eng_type(eng_type), .eng_kind(eng_kind), .ctr_req(ctr_req), .ctr_ep(ctr_ep)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input int ep, input logic [15:0] exp);
    rd_ep = IW'(ep);
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic sw_write(input int ep, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ep = IW'(ep); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xfer(input int ep, input logic [1:0] k);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_ep = IW'(ep); xfer_kind = k;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int e = 0; e < NEP; e++) check_word("R1", e, 16'h0000);
    check("R1", {15'd0, ctr_req}, 16'h0000);
  endtask

  task automatic t_plain();
    sw_write(2, 16'h0705);
    check_word("R2", 2, 16'h0705);
    sw_write(2, 16'h0203);
    check_word("R2", 2, 16'h0203);
  endtask

  task automatic t_invert();
    sw_write(1, 16'h3030); check_word("R3", 1, 16'h3030);
    sw_write(1, 16'h1010); check_word("R3", 1, 16'h2020);
    sw_write(1, 16'h0000); check_word("R3", 1, 16'h2020);
    sw_write(1, 16'h4040); check_word("R4", 1, 16'h6060);
    sw_write(1, 16'h4000); check_word("R4", 1, 16'h2060);
  endtask

  task automatic t_out_done();
    sw_write(3, 16'h3000);
    xfer(3, 2'b00);
    check_word("R6", 3, 16'hE000);
    check("R11", {14'd0, ctr_req, 1'b0} | 16'(ctr_ep) << 4, 16'h0032);
    sw_write(3, 16'h8000);
    check_word("R5", 3, 16'hE000);
    sw_write(3, 16'h0000);
    check_word("R5", 3, 16'h6000);
    check("R11", {15'd0, ctr_req}, 16'h0000);
  endtask

  task automatic t_setup();
    sw_write(0, 16'h3000);
    xfer(0, 2'b10);
    check_word("R7", 0, 16'hE800);
    check("R11", 16'(ctr_ep), 16'h0000);
    sw_write(0, 16'h8800);
    check_word("R7", 0, 16'hE800);
    sw_write(0, 16'h0000);
    check_word("R7", 0, 16'h6800);
    sw_write(0, 16'h1000);
    check_word("R3", 0, 16'h7800);
    xfer(0, 2'b00);
    check_word("R6", 0, 16'hA000);
    sw_write(0, 16'h0000);
    check_word("R5", 0, 16'h2000);
  endtask

  task automatic t_in_done();
    sw_write(5, 16'h0030);
    xfer(5, 2'b01);
    check_word("R8", 5, 16'h00E0);
    check("R11", 16'(ctr_ep), 16'h0005);
    sw_write(5, 16'h0000);
    check_word("R5", 5, 16'h0060);
  endtask

  task automatic t_ignored();
    xfer(6, 2'b00);
    check_word("R9", 6, 16'h0000);
    xfer(6, 2'b01);
    check_word("R9", 6, 16'h0000);
    xfer(5, 2'b01);
    check_word("R9", 5, 16'h0060);
    sw_write(6, 16'h3000);
    xfer(6, 2'b11);
    check_word("R9", 6, 16'h3000);
    check("R9", {15'd0, ctr_req}, 16'h0000);
  endtask

  task automatic t_priority();
    sw_write(4, 16'h0030);
    sw_write(7, 16'h0030);
    xfer(7, 2'b01);
    check("R11", {15'd0, ctr_req} | 16'(ctr_ep) << 4, 16'h0071);
    xfer(4, 2'b01);
    check("R11", 16'(ctr_ep), 16'h0004);
    sw_write(4, 16'h0000);
    check("R11", 16'(ctr_ep), 16'h0007);
    sw_write(7, 16'h0000);
    check("R11", {15'd0, ctr_req}, 16'h0000);
  endtask

  task automatic t_collide();
    sw_write(2, 16'h3203);
    check_word("R3", 2, 16'h3203);
    @(negedge clk);
    wr_en = 1'b1; wr_ep = 3'd2; wr_data = 16'h7409;
    xfer_valid = 1'b1; xfer_ep = 3'd2; xfer_kind = 2'b00;
    @(negedge clk);
    wr_en = 1'b0; xfer_valid = 1'b0;
    check_word("R10", 2, 16'hE409);
    check("R10", 16'(ctr_ep), 16'h0002);
  endtask

  task automatic t_lookup();
    eng_sel = 3'd2;
    #1;
    check("R12", {8'd0, eng_type, eng_rx_stat, eng_tx_stat, eng_rx_tog, eng_kind},
          {8'd0, 2'b10, 2'b10, 2'b00, 1'b1, 1'b0});
    check("R12", {15'd0, eng_tx_tog}, 16'h0000);
    eng_sel = 3'd1;
    #1;
    check("R12", {12'd0, eng_rx_stat, eng_tx_stat}, {12'd0, 2'b10, 2'b10});
    check("R12", {14'd0, eng_rx_tog, eng_tx_tog}, 16'h0001);
    sw_write(2, 16'h0409);
    check_word("R5", 2, 16'h6409);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_invert();
    t_out_done();
    t_setup();
    t_in_done();
    t_ignored();
    t_priority();
    t_collide();
    t_lookup();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule